// File: doc/BRIEF.md
# Reset Cause and Software Reset Request Register

This block keeps one 32-bit register that records why the system last came out of reset, and lets software ask for a new system reset. Five cause and request flags live in bits 31 to 27; every other bit reads as zero. Three of the flags are cleared by writing a one to them: bit 31 (power-on), bit 28 (button power-on) and bit 27 (button externally initiated reset). The other two are set by writing a one to them: bit 30 (software power-on request) and bit 29 (software externally initiated reset). Writing a one to either software bit makes the block emit a one-cycle system reset request.

A saturating counter tells the first reset apart from later ones. Each pulse on the reset-event input increments the counter. When the counter was zero before the event, the register is reloaded with only the power-on flag set. A software power-on request sets the counter back to zero, so the reset that follows counts as a power-on again. A software externally initiated request does not change the counter.

The register occupies the upper 32-bit word of an 8-byte slot on a simple register port. Reads return their data one cycle after the request. The block does not sequence the rest of the system through reset; it only raises the request pulse.

Top module: `rstcause_reg`

## Requirements
- R1: After the synchronous reset `rst`, a read of the register returns 0x00000000 and `sys_rst_req` is low. The event counter starts at zero.
- R2: A write to the upper word clears each of bits 31, 28 and 27 that is 1 in the write data. A 0 in those positions leaves the bit unchanged, and a write can never set these bits.
- R3: A write to the upper word sets each of bits 30 and 29 that is 1 in the write data. Writing 0 there leaves the bit unchanged. Bits 26:0 always read as 0, whatever was written.
- R4: A write to the upper word with bit 30 set zeroes the event counter and drives `sys_rst_req` high for exactly the following cycle.
- R5: A write to the upper word with bit 29 set and bit 30 clear drives `sys_rst_req` high for the following cycle and leaves the event counter unchanged.
- R6: Every `reset_evt` cycle increments the event counter. If the counter was zero before the event, the register becomes exactly 0x80000000. Otherwise the register keeps its value.
- R7: The event counter saturates at 2^CNT_W-1 and does not wrap. No run of events after the first loads the power-on value again unless software zeroes the counter.
- R8: The upper word is slot base + 4, where address bits [ADDR_W-1:3] match the slot base and bit 2 is 1. Writes to the lower word (bit 2 = 0) or to any other address change nothing and raise no request. Reads of those addresses return 0.
- R9: `rdata` is registered. It shows the register value in the cycle after a read of the upper word, and it is 0 after any cycle without such a read. A read and a write in the same cycle return the value from before the write.
- R10: When `reset_evt` and a write arrive in the same cycle, the event is handled and the write is dropped: no flag changes from the write, no request pulse, and no counter clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of register, counter and outputs |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| reset_evt | input | 1 | One cycle per system reset occurrence |
| rdata | output | 32 | Registered read data |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
If the counter is wrong, the only sign is on the register: a later event either loads 0x80000000 when it should not, or fails to load it when it should. That shows on the read one cycle after the event. The bench therefore drives event bursts longer than the counter range, and it zeroes the counter by software between events. If the masking or decode is wrong, the error shows at once, as a stray request pulse in the cycle after the write or as wrong bits on the next read. So every stimulus step compares the request line and the read data against a reference model in that same step.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int REG_W = 32;
  localparam int B_POR    = 31;
  localparam int B_SWPOR  = 30;
  localparam int B_SWXR   = 29;
  localparam int B_BTNPOR = 28;
  localparam int B_BTNXR  = 27;
  localparam logic [REG_W-1:0] USED_MASK = 32'hF800_0000;
  localparam logic [REG_W-1:0] W1C_MASK  = 32'h9800_0000;
  localparam logic [REG_W-1:0] W1S_MASK  = 32'h6000_0000;
  localparam logic [REG_W-1:0] POR_VALUE = 32'h8000_0000;

  typedef struct packed {
    logic wr_hi;
    logic rd_hi;
  } acc_t;
endpackage

// File: rtl/rstcause_decode.sv
module rstcause_decode
  import rstcause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 16'hF020
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  output acc_t              acc
);
  localparam int SLOT_LSB = 3;
  logic slot_hit;
  logic upper;
  logic unused_addr_lo;

  assign unused_addr_lo = ^addr[1:0];
  assign slot_hit = (addr[ADDR_W-1:SLOT_LSB] == SLOT_BASE[ADDR_W-1:SLOT_LSB]);
  assign upper    = addr[2];

  always_comb begin
    acc.wr_hi = wr_en & slot_hit & upper;
    acc.rd_hi = rd_en & slot_hit & upper;
  end
endmodule

// File: rtl/rstcause_counter.sv
module rstcause_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             zero
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc) begin
      if (count != CNT_MAX) count <= count + 1'b1;
    end else if (clr) begin
      count <= '0;
    end
  end

  assign zero = (count == '0);
endmodule

// File: rtl/rstcause_store.sv
module rstcause_store
  import rstcause_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load_por,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] cause
);
  logic [REG_W-1:0] used;
  logic [REG_W-1:0] nxt;

  assign used = wdata & USED_MASK;
  assign nxt  = (cause & ~(used & W1C_MASK)) | (used & W1S_MASK);

  always_ff @(posedge clk) begin
    if (rst)           cause <= '0;
    else if (load_por) cause <= POR_VALUE;
    else if (wr)       cause <= nxt;
  end
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
  import rstcause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 16'hF020,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              reset_evt,
  output logic [31:0]       rdata,
  output logic              sys_rst_req
);
  acc_t             acc;
  logic             wr_eff;
  logic             sw_por;
  logic             sw_req;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_zero;
  logic [REG_W-1:0] cause_q;

  rstcause_decode #(.ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE)) u_dec (
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .acc(acc)
  );

  // an event in the same cycle wins over a write
  assign wr_eff = acc.wr_hi & ~reset_evt;
  assign sw_por = wr_eff & wdata[B_SWPOR];
  assign sw_req = wr_eff & (wdata[B_SWPOR] | wdata[B_SWXR]);

  rstcause_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(reset_evt), .clr(sw_por),
    .count(cnt_q), .zero(cnt_zero)
  );

  rstcause_store u_store (
    .clk(clk), .rst(rst), .load_por(reset_evt & cnt_zero),
    .wr(wr_eff), .wdata(wdata), .cause(cause_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      rdata       <= acc.rd_hi ? cause_q : '0;
      sys_rst_req <= sw_req;
    end
  end
endmodule

// File: rtl/rstcause_reg_checker.sv
module rstcause_reg_checker
  import rstcause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SLOT_BASE = 16'hF020,
  parameter int CNT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              reset_evt,
  input logic [31:0]       rdata,
  input logic              sys_rst_req,
  input logic [CNT_W-1:0]  cnt,
  input logic              cnt_zero,
  input logic [31:0]       cause
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic hit_hi;
  logic unused_chk;
  assign hit_hi = (addr[ADDR_W-1:3] == SLOT_BASE[ADDR_W-1:3]) && addr[2];
  assign unused_chk = ^{addr[1:0], wdata[31], wdata[28:0]};

  assert_req_source_R4: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $past(wr_en && hit_hi && !reset_evt && (wdata[30] || wdata[29])));
  assert_swpor_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_hi && !reset_evt && wdata[30]) |=> (cnt == '0) && sys_rst_req);
  assert_swxr_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_hi && !reset_evt && !wdata[30] && wdata[29]) |=> sys_rst_req && (cnt == $past(cnt)));
  assert_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
    rdata[26:0] == 27'd0);
  assert_other_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !hit_hi) |=> rdata == 32'd0);
  assert_por_load_R6: assert property (@(posedge clk) disable iff (rst)
    (reset_evt && cnt_zero) |=> cause == POR_VALUE);
  assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (reset_evt && cnt == CMAX) |=> cnt == CMAX);
  assert_evt_wins_R10: assert property (@(posedge clk) disable iff (rst)
    reset_evt |=> !sys_rst_req);
endmodule

bind rstcause_reg rstcause_reg_checker #(
  .ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .reset_evt(reset_evt), .rdata(rdata),
  .sys_rst_req(sys_rst_req), .cnt(cnt_q), .cnt_zero(cnt_zero), .cause(cause_q)
);

// File: tb/rstcause_reg_test.sv
module rstcause_reg_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] BASE = 16'hF020;
  localparam logic [ADDR_W-1:0] A_HI = 16'hF024;
  localparam logic [ADDR_W-1:0] A_LO = 16'hF020;
  localparam logic [ADDR_W-1:0] A_XX = 16'h1004;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, reset_evt = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic sys_rst_req;

  int checks = 0, errors = 0;
  logic [31:0] m_reg = '0;
  int m_cnt = 0;

  rstcause_reg #(.ADDR_W(ADDR_W), .SLOT_BASE(BASE), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .reset_evt(reset_evt), .rdata(rdata), .sys_rst_req(sys_rst_req)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic bit is_hi(logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:3] == BASE[ADDR_W-1:3]) && a[2];
  endfunction

  function automatic logic [31:0] wr_next(logic [31:0] cur, logic [31:0] d);
    logic [31:0] u;
    u = d & 32'hF800_0000;
    return (cur & ~(u & 32'h9800_0000)) | (u & 32'h6000_0000);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle from a negedge, check at the following negedge
  task automatic step(string tag, bit w, bit r, logic [ADDR_W-1:0] a,
                      logic [31:0] d, bit e);
    logic [31:0] exp_rd;
    bit exp_req;
    wr_en = w; rd_en = r; addr = a; wdata = d; reset_evt = e;
    exp_rd  = (r && is_hi(a)) ? m_reg : 32'd0;
    exp_req = 0;
    if (e) begin
      if (m_cnt == 0) m_reg = 32'h8000_0000;
      if (m_cnt < CMAX) m_cnt++;
    end else if (w && is_hi(a)) begin
      m_reg = wr_next(m_reg, d);
      if (d[30]) begin m_cnt = 0; exp_req = 1; end
      else if (d[29]) exp_req = 1;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0; reset_evt = 0;
    chk({tag, " rdata"}, rdata, exp_rd);
    chk({tag, " req"}, {31'd0, sys_rst_req}, {31'd0, exp_req});
  endtask

  task automatic rd(string tag); step(tag, 0, 1, A_HI, 0, 0); endtask
  task automatic idle(string tag); step(tag, 0, 0, A_HI, 0, 0); endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h1D2C);
    repeat (3) @(negedge clk);
    rst = 0;
    rd("R1");                                   // reset state 0, req low
    step("R6", 0, 0, A_HI, 0, 1);               // first event -> POR value
    rd("R6");
    step("R2", 1, 0, A_HI, 32'h1800_0000, 0);   // W1C bits cannot be set
    rd("R2");
    step("R2", 1, 0, A_HI, 32'h8000_0000, 0);   // clear POR flag
    rd("R2");
    step("R5", 1, 0, A_HI, 32'h27FF_FFFF, 0);   // sets bit29, pulse
    idle("R4 pulse width");
    rd("R3");                                   // low bits read 0
    step("R3", 1, 0, A_HI, 32'h0000_0000, 0);   // zero keeps bit29
    rd("R3");
    step("R5", 0, 0, A_HI, 0, 1);               // counter kept -> no POR load
    rd("R5");
    step("R4", 1, 0, A_HI, 32'h4000_0000, 0);   // zero counter, pulse
    idle("R4");
    step("R4", 0, 0, A_HI, 0, 1);               // POR reload
    rd("R4");
    step("R9", 1, 1, A_HI, 32'h8000_0000, 0);   // read returns old value
    rd("R9");
    idle("R9 idle zero");
    step("R8", 1, 0, A_HI, 32'h2000_0000, 0);
    step("R8", 1, 0, A_LO, 32'h4000_0000, 0);   // lower word ignored
    step("R8", 1, 0, A_XX, 32'hE000_0000, 0);   // other address ignored
    step("R8", 0, 1, A_LO, 0, 0);
    step("R8", 0, 1, A_XX, 0, 0);
    rd("R8");
    step("R10", 1, 0, A_HI, 32'h4000_0000, 1);  // event wins over write
    rd("R10");
    step("R10", 0, 0, A_HI, 0, 1);              // counter not zeroed
    rd("R10");
    for (int i = 0; i < 2 * CMAX + 4; i++) step("R7", 0, 0, A_HI, 0, 1);
    rd("R7");
    step("R7", 1, 0, A_HI, 32'hFFFF_FFFF, 0);
    for (int i = 0; i < CMAX + 2; i++) step("R7", 0, 0, A_HI, 0, 1);
    rd("R7");
    for (int i = 0; i < 4000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 6) ? A_HI : (sel < 8) ? A_LO : A_XX;
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[30] = 1'b0;
      step("RND", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, d,
           $urandom_range(0, 7) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule